// File: doc/BRIEF.md
# Power-Fail Autostore and Autorecall Sequencer

This controller keeps a volatile working array and its nonvolatile shadow array in step with the supply. It watches a digitised supply-level code through a comparator with hysteresis. When the supply sags, it locks the serial front end out at once and fires a single-cycle whole-array copy into the shadow. It then holds the lockout for the longest duration the nonvolatile write can take. When the supply comes back, it copies the shadow into the working array and holds access off until that recall window has elapsed. Software may also ask for a recall while the block is running normally.

A dirty flag records whether the working array was written since the last copy in either direction. A clean array skips the store strobe, but the lockout window still runs. All phase lengths are cycle-count parameters, so a bench can shorten them. The array copies themselves live outside the block and are driven by the two strobes.

Top module: `pf_autostore_seq`

## Requirements
- R1: While `rst_n` is low, and after release, `phase` reads RESET (phase codes: RESET=0, RECALL=1, ACTIVE=2, STORE=3, OFF=4), and `access_en`, `busy`, `dirty`, `store_stb` and `recall_stb` are all low.
- R2: `supply_ok` updates one clock after `supply_code` changes. It clears when the code is below `TRIP_CODE`. It sets when the code is at least `TRIP_CODE + HYST_CODE`. Between those two values it keeps its previous value.
- R3: From RESET or OFF with `supply_ok` high, the next cycle enters RECALL with `recall_stb` high for exactly that first cycle. `access_en` then stays low for `RECALL_CYC` cycles and rises when ACTIVE is entered.
- R4: In ACTIVE, a low `supply_ok` (or a code below `POR_CODE`) moves the block to STORE on the next clock, with `access_en` low. STORE lasts `STORE_CYC` cycles and then goes to OFF.
- R5: `store_stb` is high only in the first STORE cycle, and only if `dirty` was set or `wr_en` was high in the cycle the trip was taken. Otherwise the copy is skipped while the lockout still runs.
- R6: `dirty` is set by `wr_en` only while `access_en` is high, and is cleared when STORE or RECALL is entered. `wr_en` in any other phase leaves it unchanged.
- R7: In ACTIVE, `sw_recall` starts a RECALL of `SWREC_CYC` cycles with a `recall_stb` pulse. If a trip is pending in the same cycle, the trip wins and no recall strobe appears.
- R8: A loss of `supply_ok` during RECALL goes to OFF on the next clock with no store strobe.
- R9: A supply code below `POR_CODE` while in RECALL or OFF returns the block to RESET on the next clock.
- R10: Array contents written while ACTIVE are present again in the working array after a supply loss and return, even if the working array was corrupted while OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_code | input | LVL_W | Digitised supply level |
| sw_recall | input | 1 | Software recall request, sampled in ACTIVE |
| wr_en | input | 1 | Working-array write strobe from the front end |
| access_en | output | 1 | Front end may access the working array |
| store_stb | output | 1 | One-cycle working-to-shadow copy strobe |
| recall_stb | output | 1 | One-cycle shadow-to-working copy strobe |
| busy | output | 1 | A store or recall window is running |
| dirty | output | 1 | Working array modified since the last copy |
| supply_ok | output | 1 | Hysteresis comparator output |
| phase | output | 3 | Current sequencer phase code |

## Verification
Two things can land in the same clock edge. The first is the trip decision arriving together with a front-end write. The second is the trip decision arriving together with a software recall request. The bench lowers the supply code one cycle early, so the comparator has already dropped `supply_ok` on the edge where `wr_en` and `sw_recall` are presented together. It then requires a store strobe that carries the just-written byte and no recall strobe. The written byte must read back after a scrambled power-down and a return of the supply.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;

    typedef enum logic [2:0] {
        PH_RESET  = 3'd0,
        PH_RECALL = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_STORE  = 3'd3,
        PH_OFF    = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   dirty;
        logic   store_stb;
        logic   recall_stb;
    } seq_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pf_trip_cmp.sv
module pf_trip_cmp #(
    parameter int LVL_W     = 8,
    parameter int TRIP_CODE = 120,
    parameter int HYST_CODE = 15,
    parameter int POR_CODE  = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    output logic             armed,
    output logic             below_por
);
    localparam logic [LVL_W:0] TRIP_LVL = (LVL_W+1)'(TRIP_CODE);
    localparam logic [LVL_W:0] ARM_LVL  = (LVL_W+1)'(TRIP_CODE + HYST_CODE);
    localparam logic [LVL_W:0] POR_LVL  = (LVL_W+1)'(POR_CODE);

    logic [LVL_W:0] lvl_x;
    logic           armed_d, armed_q;

    assign lvl_x = {1'b0, level};

    always_comb begin
        armed_d = armed_q;
        if (lvl_x < TRIP_LVL) begin
            armed_d = 1'b0;
        end else if (lvl_x >= ARM_LVL) begin
            armed_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

    assign armed     = armed_q;
    assign below_por = (lvl_x < POR_LVL);

endmodule

// File: rtl/pf_phase_timer.sv
module pf_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pf_autostore_seq.sv
module pf_autostore_seq
    import pf_seq_pkg::*;
#(
    parameter int LVL_W      = 8,
    parameter int TRIP_CODE  = 120,
    parameter int HYST_CODE  = 15,
    parameter int POR_CODE   = 90,
    parameter int STORE_CYC  = 1000000,
    parameter int RECALL_CYC = 20000,
    parameter int SWREC_CYC  = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] supply_code,
    input  logic             sw_recall,
    input  logic             wr_en,
    output logic             access_en,
    output logic             store_stb,
    output logic             recall_stb,
    output logic             busy,
    output logic             dirty,
    output logic             supply_ok,
    output logic [2:0]       phase
);
    localparam int MAX_CYC = max3(STORE_CYC, RECALL_CYC, SWREC_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] STORE_LD  = CNT_W'(STORE_CYC - 1);
    localparam logic [CNT_W-1:0] RECALL_LD = CNT_W'(RECALL_CYC - 1);
    localparam logic [CNT_W-1:0] SWREC_LD  = CNT_W'(SWREC_CYC - 1);
    localparam seq_t SEQ_RST = '{phase: PH_RESET, default: '0};

    logic             armed, below_por, expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    seq_t             seq_d, seq_q;

    pf_trip_cmp #(
        .LVL_W    (LVL_W),
        .TRIP_CODE(TRIP_CODE),
        .HYST_CODE(HYST_CODE),
        .POR_CODE (POR_CODE)
    ) u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (supply_code),
        .armed    (armed),
        .below_por(below_por)
    );

    pf_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (expired)
    );

    always_comb begin
        seq_d            = seq_q;
        seq_d.store_stb  = 1'b0;
        seq_d.recall_stb = 1'b0;
        tmr_load         = 1'b0;
        tmr_val          = '0;
        unique case (seq_q.phase)
            PH_RESET: begin
                seq_d.dirty = 1'b0;
                if (armed && !below_por) begin
                    seq_d.phase      = PH_RECALL;
                    seq_d.recall_stb = 1'b1;
                    tmr_load         = 1'b1;
                    tmr_val          = RECALL_LD;
                end
            end
            PH_RECALL: begin
                if (below_por) begin
                    seq_d.phase = PH_RESET;
                end else if (!armed) begin
                    seq_d.phase = PH_OFF;
                end else if (expired) begin
                    seq_d.phase = PH_ACTIVE;
                end
            end
            PH_ACTIVE: begin
                if (!armed || below_por) begin
                    seq_d.phase     = PH_STORE;
                    seq_d.store_stb = seq_q.dirty | wr_en;
                    seq_d.dirty     = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_val         = STORE_LD;
                end else if (sw_recall) begin
                    seq_d.phase      = PH_RECALL;
                    seq_d.recall_stb = 1'b1;
                    seq_d.dirty      = 1'b0;
                    tmr_load         = 1'b1;
                    tmr_val          = SWREC_LD;
                end else begin
                    seq_d.dirty = seq_q.dirty | wr_en;
                end
            end
            PH_STORE: begin
                if (expired) begin
                    seq_d.phase = PH_OFF;
                end
            end
            PH_OFF: begin
                if (below_por) begin
                    seq_d.phase = PH_RESET;
                end else if (armed) begin
                    seq_d.phase      = PH_RECALL;
                    seq_d.recall_stb = 1'b1;
                    tmr_load         = 1'b1;
                    tmr_val          = RECALL_LD;
                end
            end
            default: begin
                seq_d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign access_en  = (seq_q.phase == PH_ACTIVE);
    assign busy       = (seq_q.phase == PH_RECALL) || (seq_q.phase == PH_STORE);
    assign store_stb  = seq_q.store_stb;
    assign recall_stb = seq_q.recall_stb;
    assign dirty      = seq_q.dirty;
    assign supply_ok  = armed;
    assign phase      = seq_q.phase;

endmodule

// File: rtl/pf_autostore_chk.sv
module pf_autostore_chk #(
    parameter int LVL_W     = 8,
    parameter int TRIP_CODE = 120,
    parameter int HYST_CODE = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] supply_code,
    input logic             sw_recall,
    input logic             wr_en,
    input logic             access_en,
    input logic             store_stb,
    input logic             recall_stb,
    input logic             busy,
    input logic             dirty,
    input logic             supply_ok,
    input logic [2:0]       phase
);
    localparam logic [LVL_W:0] TRIP_LVL = (LVL_W+1)'(TRIP_CODE);
    localparam logic [LVL_W:0] ARM_LVL  = (LVL_W+1)'(TRIP_CODE + HYST_CODE);

    assert_arm_hyst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |-> ({1'b0, $past(supply_code)} >= ARM_LVL));

    assert_disarm_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_ok) |-> ({1'b0, $past(supply_code)} < TRIP_LVL));

    assert_recall_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_stb |-> (!access_en && busy));

    assert_access_after_recall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> ($past(busy) && ($past(phase) == 3'd1)));

    assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && !supply_ok) |=> (!access_en && busy));

    assert_store_needs_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |-> ($past(dirty) || $past(wr_en)));

    assert_store_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |=> !store_stb);

    assert_dirty_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty) |-> ($past(access_en) && $past(wr_en)));

    assert_trip_beats_swrec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && !supply_ok && sw_recall) |=> !recall_stb);

    assert_recall_trip_nostore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 3'd1) && !supply_ok) |=> !store_stb);

endmodule

bind pf_autostore_seq pf_autostore_chk #(
    .LVL_W    (LVL_W),
    .TRIP_CODE(TRIP_CODE),
    .HYST_CODE(HYST_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_code(supply_code),
    .sw_recall  (sw_recall),
    .wr_en      (wr_en),
    .access_en  (access_en),
    .store_stb  (store_stb),
    .recall_stb (recall_stb),
    .busy       (busy),
    .dirty      (dirty),
    .supply_ok  (supply_ok),
    .phase      (phase)
);

// File: tb/pf_autostore_seq_tb.sv
`timescale 1ns/1ps
module pf_autostore_seq_tb;
    localparam int TRIP = 120;
    localparam int HYST = 15;
    localparam int POR  = 90;
    localparam int SCYC = 12;
    localparam int RCYC = 9;
    localparam int WCYC = 5;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] supply_code = 8'd60;
    logic       sw_recall = 1'b0;
    logic       wr_en = 1'b0;
    logic       access_en, store_stb, recall_stb, busy, dirty, supply_ok;
    logic [2:0] phase;

    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] work [DEPTH];
    logic [7:0] shadow [DEPTH];
    logic [7:0] gold [DEPTH];
    int n_store = 0, n_recall = 0;
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pf_autostore_seq #(
        .LVL_W(8), .TRIP_CODE(TRIP), .HYST_CODE(HYST), .POR_CODE(POR),
        .STORE_CYC(SCYC), .RECALL_CYC(RCYC), .SWREC_CYC(WCYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_code(supply_code),
        .sw_recall(sw_recall), .wr_en(wr_en),
        .access_en(access_en), .store_stb(store_stb), .recall_stb(recall_stb),
        .busy(busy), .dirty(dirty), .supply_ok(supply_ok), .phase(phase)
    );

    // array harness driven by the strobes, sampled mid-cycle
    always @(negedge clk) begin
        if (store_stb) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] = work[i];
            n_store++;
        end
        if (recall_stb) begin
            for (int i = 0; i < DEPTH; i++) work[i] = shadow[i];
            n_recall++;
        end
        if (wr_en && access_en) work[wr_addr] = wr_data;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic power_up(input string req);
        supply_code = 8'd200;
        tick(2);
        chk(phase == 3'd1, {req, " phase RECALL"}, phase, 1);
        chk(recall_stb == 1'b1, {req, " recall strobe"}, recall_stb, 1);
        tick(RCYC - 1);
        chk(access_en == 1'b0, {req, " still locked"}, access_en, 0);
        tick(1);
        chk(access_en == 1'b1 && phase == 3'd2, {req, " access after recall"}, phase, 2);
    endtask

    task automatic power_down(input bit exp_stb, input string req);
        int s0;
        s0 = n_store;
        supply_code = 8'd100;
        tick(1);
        chk(phase == 3'd2, {req, " one cycle comparator delay"}, phase, 2);
        tick(1);
        chk(phase == 3'd3 && access_en == 1'b0, {req, " STORE lockout"}, phase, 3);
        chk(store_stb == exp_stb, {req, " store strobe"}, store_stb, int'(exp_stb));
        tick(SCYC - 1);
        chk(busy == 1'b1, {req, " busy through store"}, busy, 1);
        tick(1);
        chk(phase == 3'd4 && busy == 1'b0, {req, " OFF after store"}, phase, 4);
        chk(n_store - s0 == int'(exp_stb), {req, " store count"}, n_store - s0, int'(exp_stb));
        for (int i = 0; i < DEPTH; i++) work[i] = 8'hEE;
    endtask

    task automatic cmp_arrays(input string req);
        for (int i = 0; i < DEPTH; i++)
            chk(work[i] == gold[i], req, work[i], gold[i]);
    endtask

    initial begin
        int r0, s0;
        for (int i = 0; i < DEPTH; i++) begin work[i] = 8'h00; shadow[i] = 8'h00; gold[i] = 8'h00; end
        // R1 reset state
        tick(3);
        chk(phase == 3'd0, "R1 phase in reset", phase, 0);
        chk({access_en, busy, dirty, store_stb, recall_stb} == 5'b0, "R1 outputs in reset",
            {access_en, busy, dirty, store_stb, recall_stb}, 0);
        rst_n = 1'b1;
        tick(3);
        chk(phase == 3'd0 && access_en == 1'b0, "R1 held below POR", phase, 0);

        // R2 hysteresis sweep over every code
        for (int v = 0; v < 256; v++) begin
            supply_code = 8'd200; tick(3);
            supply_code = 8'(v); tick(2);
            chk(supply_ok == (v >= TRIP), "R2 from armed", supply_ok, int'(v >= TRIP));
            supply_code = 8'd60; tick(2);
            supply_code = 8'(v); tick(2);
            chk(supply_ok == (v >= TRIP + HYST), "R2 from disarmed", supply_ok, int'(v >= TRIP + HYST));
        end
        rst_n = 1'b0; supply_code = 8'd60; tick(2);
        rst_n = 1'b1; tick(2);

        // R3 power-up recall
        power_up("R3");
        chk(dirty == 1'b0, "R6 clean after recall", dirty, 0);

        // R6 writes mark dirty, R10 pattern
        for (int i = 0; i < DEPTH; i++) begin
            wr_byte(i, (i * 37 + 5) & 255);
            gold[i] = 8'((i * 37 + 5) & 255);
        end
        chk(dirty == 1'b1, "R6 dirty after writes", dirty, 1);

        // R4 R5 dirty store, R10 survival with hysteresis hold (R2)
        power_down(1'b1, "R4 R5");
        chk(dirty == 1'b0, "R6 cleared by store", dirty, 0);
        wr_byte(0, 8'h99);
        chk(dirty == 1'b0, "R6 write in OFF ignored", dirty, 0);
        r0 = n_recall;
        supply_code = 8'd130; tick(10);
        chk(phase == 3'd4 && n_recall == r0, "R2 no recall inside hysteresis band", phase, 4);
        power_up("R3 R10");
        cmp_arrays("R10 data survived");

        // R5 clean store skipped, lockout still applied
        power_down(1'b0, "R5 clean");
        power_up("R3 clean");
        cmp_arrays("R10 data after clean cycle");

        // R7 software recall discards a write
        wr_byte(2, 8'h11);
        chk(dirty == 1'b1, "R6 dirty before sw recall", dirty, 1);
        sw_recall = 1'b1; tick(1); sw_recall = 1'b0;
        chk(phase == 3'd1 && recall_stb == 1'b1, "R7 sw recall entered", phase, 1);
        chk(dirty == 1'b0 && access_en == 1'b0, "R7 locked clean", dirty, 0);
        tick(WCYC - 1);
        chk(busy == 1'b1, "R7 busy during sw recall", busy, 1);
        tick(1);
        chk(phase == 3'd2, "R7 active after sw recall", phase, 2);
        cmp_arrays("R7 contents restored");

        // R5 R7 collision: trip, write and sw recall on one edge
        r0 = n_recall; s0 = n_store;
        supply_code = 8'd100; tick(1);
        wr_en = 1'b1; wr_addr = 4'd7; wr_data = 8'hC3; sw_recall = 1'b1;
        tick(1);
        wr_en = 1'b0; sw_recall = 1'b0;
        gold[7] = 8'hC3;
        chk(phase == 3'd3 && store_stb == 1'b1, "R5 write in trip cycle stored", phase, 3);
        chk(n_recall == r0 && recall_stb == 1'b0, "R7 trip beats sw recall", n_recall - r0, 0);
        tick(SCYC);
        chk(phase == 3'd4 && n_store == s0 + 1, "R4 OFF after collision store", n_store - s0, 1);
        for (int i = 0; i < DEPTH; i++) work[i] = 8'hEE;
        power_up("R3 post collision");
        cmp_arrays("R10 collision byte survived");

        // R8 trip during recall
        power_down(1'b0, "R4 prep");
        s0 = n_store;
        supply_code = 8'd200; tick(2);
        chk(phase == 3'd1, "R8 in recall", phase, 1);
        supply_code = 8'd100; tick(2);
        chk(phase == 3'd4 && n_store == s0, "R8 OFF without store", phase, 4);

        // R9 below POR from OFF and from RECALL
        supply_code = 8'd60; tick(1);
        chk(phase == 3'd0, "R9 OFF to RESET", phase, 0);
        supply_code = 8'd200; tick(2);
        chk(phase == 3'd1, "R9 recall started", phase, 1);
        supply_code = 8'd60; tick(1);
        chk(phase == 3'd0, "R9 RECALL to RESET", phase, 0);

        done = 1'b1;
        summary();
    end
endmodule